// File: doc/BRIEF.md
# Compare-and-Branch / Relative-Call Sequencer

This block is the multi-cycle control slice of an 8-bit accumulator processor. It runs one instruction family, compare-and-branch-if-equal, and a relative subroutine call. The surrounding core has already fetched the opcode, the operand byte and the signed displacement. It presents them together with the current program counter, stack pointer, accumulator and index register, and it pulses `start`. The sequencer latches all of these values. It stays busy for the exact cycle count of the instruction and raises `done` in the final busy cycle. At that point the new PC, SP and X values are valid.

A compare leaves the condition flags alone. It branches only when the selected register equals the operand. The branch offset is counted from the instruction address plus the instruction length, and that length depends on the addressing form. The two index-post-increment forms bump X whether or not the branch is taken. The call stores its return address on the stack, low byte first, through a one-byte write strobe, and ends with SP lowered by two.

Top module: `cmpbr_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done` and `st_we` are low until an instruction is accepted.
- R2: `start` is accepted only when the block is idle and the code is supported. Supported codes with `prefix_sp`=0 are 0x31, 0x41, 0x51, 0x61, 0x71 and 0xAD. The only supported code with `prefix_sp`=1 is 0x61. Any other code leaves `busy`, `done` and `st_we` low.
- R3: After acceptance, `busy` is high for exactly N cycles and `done` is high only in the last of them. N is 5 for 0x31, 4 for 0x41, 4 for 0x51, 5 for 0x61, 4 for 0x71, 6 for prefixed 0x61 and 4 for 0xAD.
- R4: Code 0x51 compares X with the operand. Every other compare form compares A. The branch is taken only when the two are equal.
- R5: A taken branch gives `pc_out` = `pc_in` + L + sign-extended `rel`, modulo 2^16. L is 3 for 0x31, 0x41, 0x51 and 0x61, 2 for 0x71, and 4 for prefixed 0x61.
- R6: A branch that is not taken gives `pc_out` = `pc_in` + L, using the same L as R5.
- R7: Unprefixed 0x61 and 0x71 give `x_out` = X + 1 modulo 256, whether or not the branch is taken. All other codes give `x_out` = X. Every compare gives `sp_out` = SP.
- R8: For 0xAD, the return address is R = `pc_in` + 2. In busy cycle 2 the block writes R[7:0] to address SP. In busy cycle 3 it writes R[15:8] to address SP-1, modulo 2^16. At `done`, `sp_out` = SP-2 and `pc_out` = R + sign-extended `rel`.
- R9: `start` is ignored while busy, and all inputs are sampled only at acceptance.
- R10: No compare form raises `st_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin instruction |
| prefix_sp | input | 1 | Stack-offset prefix was fetched before `opcode` |
| opcode | input | 8 | Instruction code |
| operand | input | 8 | Fetched memory or immediate operand |
| rel | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Address of the first instruction byte |
| sp_in | input | 16 | Current stack pointer |
| acc_in | input | 8 | Accumulator |
| x_in | input | 8 | Index register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle; result ports are valid |
| pc_out | output | 16 | Next program counter |
| sp_out | output | 16 | Updated stack pointer |
| x_out | output | 8 | Updated index register |
| st_we | output | 1 | Stack byte write strobe |
| st_addr | output | 16 | Stack write address |
| st_data | output | 8 | Stack write data |

## Verification
The bench covers each addressing form with equal and unequal operands. A design with the wrong per-form length would land its branches one or two bytes away from the target, and its cycle counts would drift. The X-immediate form is given A equal to the operand but X unequal, so selecting the wrong register takes a branch that must not happen. The increment is tested at 0xFF, along with a displacement of -128, a PC wrapping past 0xFFFF and a call with SP at zero. Sign or carry mistakes in these cases produce targets or stack addresses that are off by 256 or 65536. A call that pushes the high byte first, or a start accepted mid-instruction, shows up as wrong write data or a stretched busy window.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CMPBR = 2'd1,
    OP_CALL  = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic       use_x;
    logic       post_inc;
    logic [2:0] len;
    logic [2:0] ncyc;
  } op_info_t;

  localparam logic [7:0] OPC_DIR  = 8'h31;
  localparam logic [7:0] OPC_IMMA = 8'h41;
  localparam logic [7:0] OPC_IMMX = 8'h51;
  localparam logic [7:0] OPC_IX1P = 8'h61;
  localparam logic [7:0] OPC_IXP  = 8'h71;
  localparam logic [7:0] OPC_CALL = 8'hAD;

  localparam logic [2:0] CYC_DIR  = 3'd5;
  localparam logic [2:0] CYC_IMM  = 3'd4;
  localparam logic [2:0] CYC_IX1P = 3'd5;
  localparam logic [2:0] CYC_IXP  = 3'd4;
  localparam logic [2:0] CYC_SP1  = 3'd6;
  localparam logic [2:0] CYC_CALL = 3'd4;

endpackage

// File: rtl/cmpbr_decode.sv
module cmpbr_decode
  import cmpbr_pkg::*;
(
  input  logic       prefix_sp,
  input  logic [7:0] opcode,
  output op_info_t   info
);

  always_comb begin
    info = '{kind: OP_NONE, use_x: 1'b0, post_inc: 1'b0, len: 3'd0, ncyc: 3'd0};
    if (prefix_sp) begin
      if (opcode == OPC_IX1P) begin
        info.kind = OP_CMPBR;
        info.len  = 3'd4;
        info.ncyc = CYC_SP1;
      end
    end else begin
      case (opcode)
        OPC_DIR: begin
          info.kind = OP_CMPBR;
          info.len  = 3'd3;
          info.ncyc = CYC_DIR;
        end
        OPC_IMMA: begin
          info.kind = OP_CMPBR;
          info.len  = 3'd3;
          info.ncyc = CYC_IMM;
        end
        OPC_IMMX: begin
          info.kind  = OP_CMPBR;
          info.use_x = 1'b1;
          info.len   = 3'd3;
          info.ncyc  = CYC_IMM;
        end
        OPC_IX1P: begin
          info.kind     = OP_CMPBR;
          info.post_inc = 1'b1;
          info.len      = 3'd3;
          info.ncyc     = CYC_IX1P;
        end
        OPC_IXP: begin
          info.kind     = OP_CMPBR;
          info.post_inc = 1'b1;
          info.len      = 3'd2;
          info.ncyc     = CYC_IXP;
        end
        OPC_CALL: begin
          info.kind = OP_CALL;
          info.len  = 3'd2;
          info.ncyc = CYC_CALL;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmpbr_alu.sv
module cmpbr_alu #(
  parameter int D_W = 8
) (
  input  logic           use_x,
  input  logic           post_inc,
  input  logic [D_W-1:0] acc,
  input  logic [D_W-1:0] xreg,
  input  logic [D_W-1:0] operand,
  output logic           equal,
  output logic [D_W-1:0] x_next
);

  logic [D_W-1:0] lhs;
  logic [D_W-1:0] diff;

  always_comb begin
    lhs    = use_x ? xreg : acc;
    diff   = lhs - operand;
    equal  = (diff == '0);
    x_next = post_inc ? (xreg + {{(D_W-1){1'b0}}, 1'b1}) : xreg;
  end

endmodule

// File: rtl/cmpbr_target.sv
module cmpbr_target #(
  parameter int PC_W = 16,
  parameter int D_W  = 8
) (
  input  logic [PC_W-1:0] pc,
  input  logic [D_W-1:0]  rel,
  input  logic [2:0]      len,
  input  logic            taken,
  output logic [PC_W-1:0] next_pc
);

  localparam int EXT_W = PC_W - D_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_ext;

  always_comb begin
    seq_pc  = pc + {{(PC_W-3){1'b0}}, len};
    rel_ext = {{EXT_W{rel[D_W-1]}}, rel};
    next_pc = taken ? (seq_pc + rel_ext) : seq_pc;
  end

endmodule

// File: rtl/cmpbr_stack.sv
module cmpbr_stack #(
  parameter int PC_W  = 16,
  parameter int D_W   = 8,
  parameter int CNT_W = 3
) (
  input  logic             is_call,
  input  logic             busy,
  input  logic [CNT_W-1:0] phase,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  sp,
  output logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  sp_final,
  output logic             st_we,
  output logic [PC_W-1:0]  st_addr,
  output logic [D_W-1:0]   st_data
);

  localparam int NBYTES = PC_W / D_W;
  localparam int FIRST_PUSH = 2;

  logic [D_W-1:0] ret_byte [NBYTES];
  logic [PC_W-1:0] byte_idx;

  assign ret_addr = pc + PC_W'(2);

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_bytes
    assign ret_byte[gi] = ret_addr[gi*D_W +: D_W];
  end

  always_comb begin
    byte_idx = PC_W'(phase) - PC_W'(FIRST_PUSH);
    st_we    = busy && is_call && (int'(phase) >= FIRST_PUSH)
               && (int'(phase) < FIRST_PUSH + NBYTES);
    st_addr  = sp - byte_idx;
    st_data  = '0;
    for (int bi = 0; bi < NBYTES; bi++) begin
      if (byte_idx == PC_W'(bi)) st_data = ret_byte[bi];
    end
    sp_final = is_call ? (sp - PC_W'(NBYTES)) : sp;
  end

endmodule

// File: rtl/cmpbr_seq.sv
module cmpbr_seq
  import cmpbr_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int D_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            prefix_sp,
  input  logic [D_W-1:0]  opcode,
  input  logic [D_W-1:0]  operand,
  input  logic [D_W-1:0]  rel,
  input  logic [PC_W-1:0] pc_in,
  input  logic [PC_W-1:0] sp_in,
  input  logic [D_W-1:0]  acc_in,
  input  logic [D_W-1:0]  x_in,
  output logic            busy,
  output logic            done,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] sp_out,
  output logic [D_W-1:0]  x_out,
  output logic            st_we,
  output logic [PC_W-1:0] st_addr,
  output logic [D_W-1:0]  st_data
);

  localparam int CNT_W = 3;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} state_e;

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_info_t         dec_info, info_q;
  logic [D_W-1:0]   opr_q, rel_q, acc_q, x_q;
  logic [PC_W-1:0]  pc_q, sp_q;
  logic             accept, last, ld_en;
  logic             is_call, equal, taken;
  logic [D_W-1:0]   x_next;
  logic [PC_W-1:0]  next_pc, ret_addr, sp_final;

  cmpbr_decode u_dec (
    .prefix_sp (prefix_sp),
    .opcode    (opcode),
    .info      (dec_info)
  );

  always_comb begin
    accept  = (state_q == S_IDLE) && start && (dec_info.kind != OP_NONE);
    last    = (state_q == S_RUN) && (cnt_q == info_q.ncyc);
    ld_en   = accept;
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          state_d = S_RUN;
          cnt_d   = CNT_W'(1);
        end
      end
      S_RUN: begin
        if (last) begin
          state_d = S_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = S_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= '{kind: OP_NONE, use_x: 1'b0, post_inc: 1'b0, len: 3'd0, ncyc: 3'd0};
      opr_q  <= '0;
      rel_q  <= '0;
      acc_q  <= '0;
      x_q    <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
    end else if (ld_en) begin
      info_q <= dec_info;
      opr_q  <= operand;
      rel_q  <= rel;
      acc_q  <= acc_in;
      x_q    <= x_in;
      pc_q   <= pc_in;
      sp_q   <= sp_in;
    end
  end

  assign is_call = (info_q.kind == OP_CALL);

  cmpbr_alu #(.D_W(D_W)) u_alu (
    .use_x    (info_q.use_x),
    .post_inc (info_q.post_inc),
    .acc      (acc_q),
    .xreg     (x_q),
    .operand  (opr_q),
    .equal    (equal),
    .x_next   (x_next)
  );

  assign taken = is_call || equal;

  cmpbr_target #(.PC_W(PC_W), .D_W(D_W)) u_tgt (
    .pc      (pc_q),
    .rel     (rel_q),
    .len     (info_q.len),
    .taken   (taken),
    .next_pc (next_pc)
  );

  cmpbr_stack #(.PC_W(PC_W), .D_W(D_W), .CNT_W(CNT_W)) u_stk (
    .is_call  (is_call),
    .busy     (busy),
    .phase    (cnt_q),
    .pc       (pc_q),
    .sp       (sp_q),
    .ret_addr (ret_addr),
    .sp_final (sp_final),
    .st_we    (st_we),
    .st_addr  (st_addr),
    .st_data  (st_data)
  );

  assign busy   = (state_q == S_RUN);
  assign done   = last;
  assign pc_out = next_pc;
  assign sp_out = sp_final;
  assign x_out  = is_call ? x_q : x_next;

endmodule

// File: rtl/cmpbr_seq_chk.sv
module cmpbr_seq_chk #(
  parameter int PC_W = 16,
  parameter int D_W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            st_we,
  input logic [PC_W-1:0] st_addr,
  input logic [D_W-1:0]  st_data
);

  a_r3_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r9_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r8_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (busy && !done));

  a_r8_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && $past(st_we)) |-> (st_addr == $past(st_addr) - PC_W'(1)));

  a_r8_data_known: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> !$isunknown(st_data));

endmodule

bind cmpbr_seq cmpbr_seq_chk #(.PC_W(PC_W), .D_W(D_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .st_we   (st_we),
  .st_addr (st_addr),
  .st_data (st_data)
);

// File: tb/tb_cmpbr_seq.sv
module tb_cmpbr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        prefix_sp = 1'b0;
  logic [7:0]  opcode = 8'h00, operand = 8'h00, rel = 8'h00, acc_in = 8'h00, x_in = 8'h00;
  logic [15:0] pc_in = 16'h0, sp_in = 16'h0;
  logic        busy, done, st_we;
  logic [15:0] pc_out, sp_out, st_addr;
  logic [7:0]  x_out, st_data;

  always #4 clk = ~clk;

  cmpbr_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prefix_sp(prefix_sp),
    .opcode(opcode), .operand(operand), .rel(rel), .pc_in(pc_in),
    .sp_in(sp_in), .acc_in(acc_in), .x_in(x_in), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out), .x_out(x_out), .st_we(st_we),
    .st_addr(st_addr), .st_data(st_data)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string tag = "R1";

  // reference model state
  int          m_idx = 0;
  int          m_n = 0;
  bit          m_call = 0;
  logic [15:0] m_pc, m_sp, m_ret;
  logic [7:0]  m_x;
  logic [7:0]  mem [logic [15:0]];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0;
    end else if (m_idx != 0) begin
      if (m_st_we_exp()) mem[m_st_addr_exp()] = m_st_data_exp();
      if (m_idx == m_n) m_idx = 0;
      else m_idx++;
    end else if (start) begin
      int n, len;
      bit eq, inc, is_call;
      logic [7:0] lhs;
      n = 0; len = 0; inc = 0; is_call = 0;
      lhs = acc_in;
      if (prefix_sp) begin
        if (opcode == 8'h61) begin n = 6; len = 4; end
      end else begin
        case (opcode)
          8'h31: begin n = 5; len = 3; end
          8'h41: begin n = 4; len = 3; end
          8'h51: begin n = 4; len = 3; lhs = x_in; end
          8'h61: begin n = 5; len = 3; inc = 1; end
          8'h71: begin n = 4; len = 2; inc = 1; end
          8'hAD: begin n = 4; len = 2; is_call = 1; end
          default: n = 0;
        endcase
      end
      if (n > 0) begin
        eq     = (lhs == operand);
        m_n    = n;
        m_idx  = 1;
        m_call = is_call;
        m_ret  = pc_in + 16'd2;
        if (is_call) begin
          m_pc = m_ret + {{8{rel[7]}}, rel};
          m_sp = sp_in - 16'd2;
          m_x  = x_in;
        end else begin
          m_pc = pc_in + 16'(len) + (eq ? {{8{rel[7]}}, rel} : 16'h0);
          m_sp = sp_in;
          m_x  = inc ? x_in + 8'd1 : x_in;
        end
        m_sp_base = sp_in;
      end
    end
  end

  logic [15:0] m_sp_base = 16'h0;

  function automatic bit m_st_we_exp();
    return (m_idx != 0) && m_call && (m_idx == 2 || m_idx == 3);
  endfunction
  function automatic logic [15:0] m_st_addr_exp();
    return (m_idx == 2) ? m_sp_base : m_sp_base - 16'd1;
  endfunction
  function automatic logic [7:0] m_st_data_exp();
    return (m_idx == 2) ? m_ret[7:0] : m_ret[15:8];
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(tag, "busy", {15'h0, busy}, {15'h0, m_idx != 0});
      chk(tag, "done", {15'h0, done}, {15'h0, (m_idx != 0) && (m_idx == m_n)});
      chk(m_call ? "R8" : "R10", "st_we", {15'h0, st_we}, {15'h0, m_st_we_exp()});
      if (m_st_we_exp()) begin
        chk("R8", "st_addr", st_addr, m_st_addr_exp());
        chk("R8", "st_data", {8'h0, st_data}, {8'h0, m_st_data_exp()});
      end
      if ((m_idx != 0) && (m_idx == m_n)) begin
        chk(tag, "pc_out", pc_out, m_pc);
        chk(m_call ? "R8" : "R7", "sp_out", sp_out, m_sp);
        chk(m_call ? tag : "R7", "x_out", {8'h0, x_out}, {8'h0, m_x});
      end
    end
  end

  task automatic issue(string t, bit pre, logic [7:0] opc, logic [7:0] opr, logic [7:0] rl,
                       logic [15:0] pc, logic [15:0] sp, logic [7:0] a, logic [7:0] x,
                       int poke = 0);
    @(negedge clk);
    tag = t;
    prefix_sp = pre; opcode = opc; operand = opr; rel = rl;
    pc_in = pc; sp_in = sp; acc_in = a; x_in = x;
    start = 1'b1;
    @(negedge clk);
    // scramble inputs: they must have been captured at acceptance (R9)
    operand = ~opr; rel = ~rl; pc_in = pc ^ 16'h5A5A; sp_in = ~sp; acc_in = ~a; x_in = ~x;
    opcode = 8'h41; prefix_sp = 1'b0;
    start = (poke > 0);
    for (int k = 1; k < poke; k++) @(negedge clk);
    start = 1'b0;
    while (m_idx != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue("R4", 0, 8'h31, 8'h22, 8'h10, 16'h1000, 16'h00F0, 8'h22, 8'h00);
    issue("R6", 0, 8'h31, 8'h23, 8'h10, 16'h1000, 16'h00F0, 8'h22, 8'h00);
    issue("R5", 0, 8'h41, 8'h7E, 8'h80, 16'h2000, 16'h00F0, 8'h7E, 8'h01);
    issue("R4", 0, 8'h51, 8'h44, 8'h05, 16'h0200, 16'h00F0, 8'h10, 8'h44);
    issue("R4", 0, 8'h51, 8'h44, 8'h05, 16'h0200, 16'h00F0, 8'h44, 8'h45);
    issue("R7", 0, 8'h61, 8'h09, 8'h20, 16'h0300, 16'h00F0, 8'h09, 8'hFF);
    issue("R7", 0, 8'h61, 8'h08, 8'h20, 16'h0300, 16'h00F0, 8'h09, 8'h12);
    issue("R5", 0, 8'h71, 8'hA0, 8'hFE, 16'h0400, 16'h00F0, 8'hA0, 8'h30);
    issue("R6", 0, 8'h71, 8'hA1, 8'hFE, 16'h0400, 16'h00F0, 8'hA0, 8'h30);
    issue("R5", 1, 8'h61, 8'h5C, 8'h40, 16'h0500, 16'h00F0, 8'h5C, 8'h77);
    issue("R6", 1, 8'h61, 8'h5D, 8'h40, 16'h0500, 16'h00F0, 8'h5C, 8'h77);
    issue("R5", 0, 8'h41, 8'h00, 8'h7F, 16'hFFF0, 16'h00F0, 8'h00, 8'h00);
    issue("R8", 0, 8'hAD, 8'h00, 8'hF0, 16'h3456, 16'h00FF, 8'h11, 8'h22);
    issue("R8", 0, 8'hAD, 8'h00, 8'h01, 16'hFFFF, 16'h0000, 8'h11, 8'h22);
    issue("R2", 0, 8'h81, 8'h00, 8'h01, 16'h0100, 16'h00F0, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    issue("R2", 1, 8'h31, 8'h00, 8'h01, 16'h0100, 16'h00F0, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    issue("R9", 0, 8'hAD, 8'h00, 8'h10, 16'h0800, 16'h0080, 8'h00, 8'h00, 3);
    issue("R3", 1, 8'h61, 8'h01, 8'h02, 16'h0900, 16'h0080, 8'h01, 8'h00);
    repeat (2) @(negedge clk);

    // stack contents written by the first call (R8)
    chk("R8", "mem[00FF]", {8'h0, mem.exists(16'h00FF) ? mem[16'h00FF] : 8'hXX}, 16'h0058);
    chk("R8", "mem[00FE]", {8'h0, mem.exists(16'h00FE) ? mem[16'h00FE] : 8'hXX}, 16'h0034);
    chk("R8", "mem[FFFF]", {8'h0, mem.exists(16'hFFFF) ? mem[16'hFFFF] : 8'hXX}, 16'h0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule